// File: doc/BRIEF.md
# Horizontal Sync Phase Aligner by Clock Swallowing

This block keeps a locally derived timing chain in step with an incoming horizontal sync. A free-running master clock feeds a divide-by-four instruction-phase counter and a line counter. Both counters advance only while a registered clock enable is high. Once per line, at a fixed count shortly before the local chain expects the sync edge, the block looks at the synchronized sync level. A sync that has already gone low means the video is ahead. In that case the enable drops for exactly one master clock, which retards the whole local chain by a quarter of an instruction cycle. A sync that is still high leaves the line untouched.

Correction works in one direction only and in single-clock steps, so the block behaves as a bang-bang loop. The line length in master clocks does not have to be a multiple of four. With the default of 910 clocks, the instruction phase at line start moves by half an instruction cycle from one line to the next. A lock flag reports whether the correction pattern has settled: no correction at all, or corrections that alternate line by line.

Top module: `hsync_aligner`

## Requirements
- R1: `instr_stb` pulses once every 4 cycles in which `clk_en` is high. The instruction phase free-runs and is never realigned to the line start.
- R2: `line_stb` pulses once every LINE_LEN cycles in which `clk_en` is high. After a `line_stb` the line count restarts at 0.
- R3: Each line's decision uses `hsync_n` after a synchronizer of SYNC_STAGES flops. The sample is taken at line count LINE_LEN − SAMPLE_LEAD + SYNC_STAGES. A high (1) sample means the edge has not yet arrived: `clk_en` stays high and the line lasts LINE_LEN clocks.
- R4: A low (0) sample means the edge has already arrived. `clk_en` goes low for exactly the one clock after the sample cycle, and that line lasts LINE_LEN + 1 clocks.
- R5: At most one clock is withheld per line, and `clk_en` is never low on two consecutive clocks.
- R6: A line counts as "settled" unless it and the line before it were both corrected. `locked` rises at the end of the 8th consecutive settled line.
- R7: `locked` falls at the end of the 4th consecutive corrected line. Three consecutive corrected lines followed by an uncorrected one leave it set.
- R8: While `rst_n` is low, `clk_en` is 1, `locked`, `instr_stb` and `line_stb` are 0, and `hsync_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | Asynchronous active-low horizontal sync |
| clk_en | output | 1 | Registered enable for downstream timing; low for one clock on a correction |
| instr_stb | output | 1 | Instruction-rate strobe, one per four enabled clocks |
| line_stb | output | 1 | Strobe on the last enabled clock of each local line |
| locked | output | 1 | Correction pattern has settled |

## Verification
The bench builds the block with a 30-clock line, a sample lead of 4 clocks and the default two-flop synchronizer, with lock after 8 settled lines and unlock after 4 corrected lines. The short line lets one run cover many lock and unlock transitions, including the boundary case of three corrected lines that must not unlock. Because 30 is not a multiple of four, the instruction phase shifts by half an instruction cycle at every line start, so the divide-by-four check runs across line boundaries rather than resetting with them.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

   // Minimum flops in the sync synchronizer
   localparam int MIN_SYNC_STAGES = 2;

   // Outcome of the once-per-line sync sample
   typedef enum logic {
      VERDICT_EARLY = 1'b0,
      VERDICT_LATE  = 1'b1
   } verdict_e;

endpackage

// File: rtl/hsa_sync.sv
module hsa_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < hsa_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
         $error("hsa_sync: STAGES below minimum");
      end
   endgenerate

   // Idle level of an active-low sync is high
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/hsa_timebase.sv
module hsa_timebase #(
   parameter int INSTR_DIV = 4,
   parameter int LINE_LEN  = 910,
   parameter int SAMPLE_AT = 904,
   localparam int PW = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1,
   localparam int LW = $clog2(LINE_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [PW-1:0] phase,
   output logic [LW-1:0] line_cnt,
   output logic          instr_stb,
   output logic          line_stb,
   output logic          sample_hit
);
   localparam logic [PW-1:0] PH_LAST   = PW'(INSTR_DIV - 1);
   localparam logic [LW-1:0] LINE_LAST = LW'(LINE_LEN - 1);
   localparam logic [LW-1:0] SMP_POS   = LW'(SAMPLE_AT);

   logic [PW-1:0] phase_nxt;

   generate
      if (INSTR_DIV < 2) begin : g_bad_div
         $error("hsa_timebase: INSTR_DIV must be at least 2");
      end
      if ((INSTR_DIV & (INSTR_DIV - 1)) == 0) begin : g_pow2
         // natural binary wrap
         assign phase_nxt = phase + 1'b1;
      end else begin : g_modn
         assign phase_nxt = (phase == PH_LAST) ? '0 : phase + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= '0;
         line_cnt <= '0;
      end else if (en) begin
         phase    <= phase_nxt;
         line_cnt <= (line_cnt == LINE_LAST) ? '0 : line_cnt + 1'b1;
      end
   end

   assign instr_stb  = en && (phase == PH_LAST);
   assign line_stb   = en && (line_cnt == LINE_LAST);
   assign sample_hit = en && (line_cnt == SMP_POS);
endmodule

// File: rtl/hsa_lock.sv
module hsa_lock #(
   parameter int LOCK_LINES   = 8,
   parameter int UNLOCK_LINES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              decide,
   input  hsa_pkg::verdict_e verdict,
   output logic              locked
);
   import hsa_pkg::*;

   localparam int GW = $clog2(LOCK_LINES + 1);
   localparam int UW = $clog2(UNLOCK_LINES + 1);
   localparam logic [GW-1:0] G_TOP = GW'(LOCK_LINES);
   localparam logic [UW-1:0] U_TOP = UW'(UNLOCK_LINES);

   generate
      if (LOCK_LINES < 1 || UNLOCK_LINES < 1) begin : g_bad_counts
         $error("hsa_lock: line counts must be positive");
      end
   endgenerate

   logic          prev_late;
   logic [GW-1:0] good_run, good_nxt;
   logic [UW-1:0] corr_run, corr_nxt;
   logic          late, back_to_back;

   assign late         = (verdict == VERDICT_LATE);
   assign back_to_back = late && prev_late;

   always_comb begin
      if (back_to_back)        good_nxt = '0;
      else if (good_run == G_TOP) good_nxt = good_run;
      else                     good_nxt = good_run + 1'b1;

      if (!late)               corr_nxt = '0;
      else if (corr_run == U_TOP) corr_nxt = corr_run;
      else                     corr_nxt = corr_run + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_late <= 1'b0;
         good_run  <= '0;
         corr_run  <= '0;
         locked    <= 1'b0;
      end else if (decide) begin
         prev_late <= late;
         good_run  <= good_nxt;
         corr_run  <= corr_nxt;
         if (late && corr_nxt == U_TOP)
            locked <= 1'b0;
         else if (!back_to_back && good_nxt == G_TOP)
            locked <= 1'b1;
      end
   end
endmodule

// File: rtl/hsync_aligner.sv
module hsync_aligner #(
   parameter int INSTR_DIV    = 4,
   parameter int LINE_LEN     = 910,
   parameter int SAMPLE_LEAD  = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int LOCK_LINES   = 8,
   parameter int UNLOCK_LINES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hsync_n,
   output logic clk_en,
   output logic instr_stb,
   output logic line_stb,
   output logic locked
);
   import hsa_pkg::*;

   // Expected edge sits at count 0; the synchronizer delays what is seen
   localparam int SAMPLE_AT  = LINE_LEN - SAMPLE_LEAD + SYNC_STAGES;
   localparam int SWALLOW_AT = SAMPLE_AT + 1;
   localparam int PW = (INSTR_DIV > 1) ? $clog2(INSTR_DIV) : 1;
   localparam int LW = $clog2(LINE_LEN);

   generate
      if (SAMPLE_LEAD <= SYNC_STAGES + 1 || SAMPLE_LEAD >= LINE_LEN) begin : g_bad_lead
         $error("hsync_aligner: SAMPLE_LEAD out of range");
      end
   endgenerate

   logic          sync_s;
   logic          en_q;
   logic          sample_hit;
   logic [PW-1:0] phase;
   logic [LW-1:0] line_cnt;
   verdict_e      verdict;

   hsa_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (hsync_n),
      .dout (sync_s)
   );

   hsa_timebase #(
      .INSTR_DIV(INSTR_DIV),
      .LINE_LEN (LINE_LEN),
      .SAMPLE_AT(SAMPLE_AT)
   ) u_tb (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en_q),
      .phase     (phase),
      .line_cnt  (line_cnt),
      .instr_stb (instr_stb),
      .line_stb  (line_stb),
      .sample_hit(sample_hit)
   );

   assign verdict = sync_s ? VERDICT_EARLY : VERDICT_LATE;

   // Registered swallow decision: enable drops for the clock after the sample
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b1;
      else        en_q <= !(sample_hit && verdict == VERDICT_LATE);
   end

   hsa_lock #(
      .LOCK_LINES  (LOCK_LINES),
      .UNLOCK_LINES(UNLOCK_LINES)
   ) u_lock (
      .clk    (clk),
      .rst_n  (rst_n),
      .decide (sample_hit),
      .verdict(verdict),
      .locked (locked)
   );

   assign clk_en = en_q;
endmodule

// File: rtl/hsync_aligner_chk.sv
module hsync_aligner_chk #(
   parameter int PW = 2,
   parameter int LW = 10,
   parameter int SWALLOW_AT = 905
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clk_en,
   input logic          instr_stb,
   input logic          line_stb,
   input logic          locked,
   input logic          sync_s,
   input logic          sample_hit,
   input logic [PW-1:0] phase,
   input logic [LW-1:0] line_cnt
);
   // R5
   no_double_swallow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> clk_en);

   // R4
   swallow_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> (line_cnt == LW'(SWALLOW_AT)));

   // R1
   phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      instr_stb |=> (phase == '0));

   // R2
   line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_stb |=> (line_cnt == '0));

   // R6
   lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(sample_hit));

   // R7
   lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(sample_hit && !sync_s));
endmodule

bind hsync_aligner hsync_aligner_chk #(
   .PW(PW),
   .LW(LW),
   .SWALLOW_AT(SWALLOW_AT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clk_en    (clk_en),
   .instr_stb (instr_stb),
   .line_stb  (line_stb),
   .locked    (locked),
   .sync_s    (sync_s),
   .sample_hit(sample_hit),
   .phase     (phase),
   .line_cnt  (line_cnt)
);

// File: tb/hsync_aligner_test.sv
module hsync_aligner_test;
   localparam int LINE_LEN = 30;
   localparam int LEAD     = 4;
   localparam int LOCK_N   = 8;
   localparam int UNLOCK_N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_n = 1'b0;
   logic clk_en, instr_stb, line_stb, locked;

   always #5 clk = ~clk;

   hsync_aligner #(
      .INSTR_DIV(4), .LINE_LEN(LINE_LEN), .SAMPLE_LEAD(LEAD),
      .SYNC_STAGES(2), .LOCK_LINES(LOCK_N), .UNLOCK_LINES(UNLOCK_N)
   ) uut (
      .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n),
      .clk_en(clk_en), .instr_stb(instr_stb), .line_stb(line_stb), .locked(locked)
   );

   typedef struct {
      int period;   // 0 = not measured
      int late;
      int lock;
   } exp_t;

   exp_t exp_q[$];
   bit   pattern[$];
   int   total = 0;
   int   bad = 0;
   bit   done = 0;
   bit   reported = 0;
   int   lines_seen = 0;

   // independent model of the lock rule
   int m_prev = 0, m_good = 0, m_corr = 0, m_lock = 0;

   task automatic check(string req, bit ok, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   task automatic push_line(bit late, bit measured);
      exp_t e;
      bit both;
      both   = late && (m_prev != 0);
      m_good = both ? 0 : m_good + 1;
      m_corr = late ? m_corr + 1 : 0;
      if (late && m_corr >= UNLOCK_N)       m_lock = 0;
      else if (!both && m_good >= LOCK_N)   m_lock = 1;
      m_prev = late;
      e.period = measured ? LINE_LEN + late : 0;
      e.late   = late;
      e.lock   = m_lock;
      exp_q.push_back(e);
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
      end
   endtask

   // stimulus: 1 = sync already low at the sample point
   initial begin
      for (int i = 0; i < 10; i++) pattern.push_back(1'b0); // lock (R6)
      for (int i = 0; i < 10; i++) pattern.push_back(i[0] ? 1'b0 : 1'b1); // alternating keeps lock
      for (int i = 0; i < 3; i++)  pattern.push_back(1'b1); // three: no unlock (R7)
      pattern.push_back(1'b0);
      for (int i = 0; i < 6; i++)  pattern.push_back(1'b1); // unlock on 4th (R7)
      for (int i = 0; i < 10; i++) pattern.push_back(i[0] ? 1'b1 : 1'b0); // relock
      for (int i = 0; i < 6; i++)  pattern.push_back(1'b0);
   end

   // reset and driver
   initial begin
      repeat (3) @(negedge clk);
      hsync_n = 1'b0;
      @(negedge clk);
      hsync_n = 1'b1;
      // R8 reset state, sync activity ignored
      check("R8 clk_en", clk_en == 1'b1, clk_en, 1);
      check("R8 locked", locked == 1'b0, locked, 0);
      check("R8 line_stb", line_stb == 1'b0, line_stb, 0);
      check("R8 instr_stb", instr_stb == 1'b0, instr_stb, 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      push_line(pattern[0], 1'b0);
      for (int i = 1; i < pattern.size(); i++) begin
         do @(negedge clk); while (!line_stb);
         hsync_n = !pattern[i];
         push_line(pattern[i], 1'b1);
      end
   end

   // monitor: line periods, swallow counts, lock flag (scoreboard)
   initial begin
      int cyc = 0;
      int lows = 0;
      exp_t e;
      @(posedge rst_n);
      while (lines_seen < pattern.size()) begin
         @(negedge clk);
         cyc++;
         if (!clk_en) lows++;
         if (line_stb) begin
            if (exp_q.size() == 0) begin
               check("R2 scoreboard empty", 1'b0, 0, 1);
            end else begin
               e = exp_q.pop_front();
               if (e.period != 0) begin
                  // R3 / R4: line length follows the sample verdict
                  check(e.late ? "R4 period" : "R3 period", cyc == e.period, cyc, e.period);
                  // R5: one withheld clock at most
                  check("R5 swallow count", lows == e.late, lows, e.late);
               end
               check(e.lock ? "R6 locked" : "R7 locked", locked == e.lock[0], locked, e.lock);
            end
            lines_seen++;
            cyc = 0;
            lows = 0;
         end
      end
      done = 1;
   end

   // monitor: instruction strobe every 4 enabled clocks (R1)
   initial begin
      int en_cnt = 0;
      @(posedge rst_n);
      while (!done) begin
         @(negedge clk);
         if (clk_en) en_cnt++;
         if (instr_stb) begin
            check("R1 instr spacing", en_cnt == 4, en_cnt, 4);
            en_cnt = 0;
         end
      end
   end

   initial begin
      wait (done);
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

   initial begin
      #(200000 * 10);
      check("watchdog", 1'b0, 0, 1);
      summary();
      $finish;
   end
endmodule